// File: doc/BRIEF.md
# SPI Host Register Front-End

This block is the register side of a multi-IO SPI host controller. A bus master reaches it through a 32-bit register port. It decodes writes and reads for the global configuration word, a controller enable, an interrupt status word, and two interrupt masks. It also decodes a group of transmit data ports and a single receive data port. The configuration word is passed unchanged to the rest of the controller, which decodes the chip-select, clock-mode, idle-level and IO-width fields.

Transmit words are queued in a small buffer. The byte count of each word comes from which of four transmit addresses was written, so no separate length register is needed. Queued words go to a separate shift engine over a valid/ready handshake. For every word it sends, the engine returns one word of received bytes, aligned to the low end. The front-end repacks each received word so that its bytes sit at the top of the word, where software expects them. A level interrupt output combines the status bits with both masks.

Top module: `spi_host_regs`

## Requirements
- R1: After reset, the configuration, enable and both mask registers read 0. Status (offset 0x4) reads 0x0B. `irq`, `tx_valid` and `rx_ready` are low.
- R2: Writes at 0x0, 0x8, 0xC and 0x10 read back from the same offsets. All 32 bits are kept at 0x0, the low 5 bits at 0x8 and 0xC, and bit 0 at 0x10. `cfg_word` equals the value stored at 0x0 and `ctrl_en` equals the value stored at 0x10. Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R3: A write at 0x14 + 4*k (k = 0..3) queues the data word with a byte count of 4 when k = 0, and k otherwise. The word reaches `tx_word` unchanged, with byte lane 0 as the first byte to be shifted.
- R4: Queued transmit words leave in write order. Up to TX_DEPTH (default 4) words can be held. `tx_valid` is high while the controller is enabled and the buffer holds a word.
- R5: A transmit write while the buffer is full is dropped and sets sticky status bit 4. Writing 1 to bit 4 at 0x4 clears it. Writes at 0x4 do not change status bits 0 to 3.
- R6: The engine returns a word with n received bytes in its low byte lanes. A read at 0x24 returns that word shifted left by 8*(4-n) and removes it. A read at 0x24 while the receive buffer is empty returns 0.
- R7: Status bits show the live buffer state: bit 0 transmit empty, bit 1 transmit not full, bit 2 receive not empty, bit 3 receive not full.
- R8: `irq` is high exactly when some status bit is set in the status word, in the mask at 0x8 and in the mask at 0xC.
- R9: While the enable bit is 0, both buffers are flushed and kept empty. Transmit writes are then dropped without setting the overflow flag, and `tx_valid` stays low.
- R10: `rx_ready` is high exactly when the controller is enabled and the receive buffer holds fewer than RX_DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| cfg_word | output | 32 | Configuration word to the controller |
| ctrl_en | output | 1 | Controller enable |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit word available |
| tx_ready | input | 1 | Engine accepts a transmit word |
| tx_word | output | 32 | Transmit word, lane 0 sent first |
| tx_nbytes | output | 3 | Valid bytes in the transmit word (1..4) |
| rx_valid | input | 1 | Engine offers a received word |
| rx_ready | output | 1 | Receive buffer can accept a word |
| rx_word | input | 32 | Received bytes in the low lanes |
| rx_nbytes | input | 3 | Received byte count (1..4) |

## Verification
The transmit path runs for a long random phase. The engine's readiness changes every cycle, and writes land on random byte-count ports. This exercises the byte-count decode, the ordering and drop-on-full together against a queue model. Directed runs then fill each buffer and read at the boundaries. They separate a lost word from a reordered one, and a live status bit from a sticky one. Receive words with one, three and four bytes show whether the repacking shift depends on the byte count. A disable with words still queued shows whether the buffers are flushed or just hidden.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam logic [7:0] OFS_CFG  = 8'h00;
  localparam logic [7:0] OFS_STS  = 8'h04;
  localparam logic [7:0] OFS_STEN = 8'h08;
  localparam logic [7:0] OFS_SGEN = 8'h0C;
  localparam logic [7:0] OFS_ENA  = 8'h10;
  localparam logic [7:0] OFS_TXD0 = 8'h14;
  localparam logic [7:0] OFS_TXD3 = 8'h20;
  localparam logic [7:0] OFS_RXD  = 8'h24;

  localparam int STS_W     = 5;
  localparam int B_TXEMPTY = 0;
  localparam int B_TXNFULL = 1;
  localparam int B_RXNEMP  = 2;
  localparam int B_RXNFULL = 3;
  localparam int B_TXOVF   = 4;

  typedef struct packed {
    logic [31:0] word;
    logic [2:0]  nbytes;
  } tx_ent_t;
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (push && !pop) cnt_d = cnt_q + 1'b1;
      else if (pop && !push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  AST_FIFO_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);  // R5
  AST_FIFO_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);  // R6
  AST_FIFO_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush) |=> (cnt_q == $past(cnt_q) - 1'b1));  // R4
endmodule

// File: rtl/spi_host_irq.sv
module spi_host_irq
  import spi_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       live,
  input  logic             ovf_set,
  input  logic             ovf_clr,
  input  logic             wr_sten,
  input  logic             wr_sgen,
  input  logic [STS_W-1:0] wdata,
  output logic [STS_W-1:0] status,
  output logic [STS_W-1:0] sten,
  output logic [STS_W-1:0] sgen,
  output logic             irq
);
  logic             ovf_q, ovf_d;
  logic [STS_W-1:0] sten_q, sten_d, sgen_q, sgen_d;

  always_comb begin
    ovf_d  = ovf_q;
    if (ovf_clr) ovf_d = 1'b0;
    if (ovf_set) ovf_d = 1'b1;
    sten_d = wr_sten ? wdata : sten_q;
    sgen_d = wr_sgen ? wdata : sgen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      sten_q <= '0;
      sgen_q <= '0;
    end else begin
      ovf_q  <= ovf_d;
      sten_q <= sten_d;
      sgen_q <= sgen_d;
    end
  end

  assign status = {ovf_q, live};
  assign sten   = sten_q;
  assign sgen   = sgen_q;
  assign irq    = |(status & sten_q & sgen_q);

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);  // R5
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> status[B_TXOVF]);  // R5
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic [31:0] cfg_word,
  output logic        ctrl_en,
  output logic        irq,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_word,
  output logic [2:0]  tx_nbytes,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [31:0] rx_word,
  input  logic [2:0]  rx_nbytes
);
  localparam int TXW = $bits(tx_ent_t);

  logic [31:0] cfg_q, cfg_d, rdata_q, rdata_d;
  logic        en_q, en_d;

  logic        tx_hit, tx_push, tx_pop, tx_empty, tx_full, tx_ovf;
  logic [7:0]  tx_off;
  tx_ent_t     tx_in, tx_out;
  logic        rx_push, rx_pop, rx_empty, rx_full;
  logic [31:0] rx_packed, rx_head;
  logic [5:0]  rx_shamt;

  logic [STS_W-1:0] status, sten, sgen;
  logic [3:0]       live;

  // transmit port decode: four consecutive word addresses
  assign tx_off  = reg_addr - OFS_TXD0;
  assign tx_hit  = reg_wr && (reg_addr >= OFS_TXD0) && (reg_addr <= OFS_TXD3)
                   && (reg_addr[1:0] == 2'b00);
  assign tx_push = tx_hit && en_q && !tx_full;
  assign tx_ovf  = tx_hit && en_q && tx_full;
  assign tx_in.word   = reg_wdata;
  assign tx_in.nbytes = (tx_off[3:2] == 2'd0) ? 3'd4 : {1'b0, tx_off[3:2]};
  assign tx_pop  = tx_valid && tx_ready;

  spi_host_fifo #(.W(TXW), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(!en_q),
    .push(tx_push), .din(tx_in), .pop(tx_pop),
    .dout(tx_out), .empty(tx_empty), .full(tx_full));

  assign tx_valid  = en_q && !tx_empty;
  assign tx_word   = tx_out.word;
  assign tx_nbytes = tx_out.nbytes;

  // receive repacking: bytes move to the top of the word
  assign rx_shamt  = {(3'd4 - rx_nbytes), 3'b000};
  assign rx_packed = rx_word << rx_shamt;
  assign rx_ready  = en_q && !rx_full;
  assign rx_push   = rx_valid && rx_ready;
  assign rx_pop    = reg_rd && (reg_addr == OFS_RXD) && !rx_empty;

  spi_host_fifo #(.W(32), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(!en_q),
    .push(rx_push), .din(rx_packed), .pop(rx_pop),
    .dout(rx_head), .empty(rx_empty), .full(rx_full));

  assign live[B_TXEMPTY] = tx_empty;
  assign live[B_TXNFULL] = !tx_full;
  assign live[B_RXNEMP]  = !rx_empty;
  assign live[B_RXNFULL] = !rx_full;

  spi_host_irq u_irq (
    .clk(clk), .rst_n(rst_n), .live(live),
    .ovf_set(tx_ovf),
    .ovf_clr(reg_wr && (reg_addr == OFS_STS) && reg_wdata[B_TXOVF]),
    .wr_sten(reg_wr && (reg_addr == OFS_STEN)),
    .wr_sgen(reg_wr && (reg_addr == OFS_SGEN)),
    .wdata(reg_wdata[STS_W-1:0]),
    .status(status), .sten(sten), .sgen(sgen), .irq(irq));

  always_comb begin
    cfg_d = (reg_wr && reg_addr == OFS_CFG) ? reg_wdata : cfg_q;
    en_d  = (reg_wr && reg_addr == OFS_ENA) ? reg_wdata[0] : en_q;
    rdata_d = rdata_q;
    if (reg_rd) begin
      unique case (reg_addr)
        OFS_CFG:  rdata_d = cfg_q;
        OFS_STS:  rdata_d = 32'(status);
        OFS_STEN: rdata_d = 32'(sten);
        OFS_SGEN: rdata_d = 32'(sgen);
        OFS_ENA:  rdata_d = {31'd0, en_q};
        OFS_RXD:  rdata_d = rx_empty ? 32'd0 : rx_head;
        default:  rdata_d = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      en_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      en_q    <= en_d;
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign cfg_word  = cfg_q;
  assign ctrl_en   = en_q;

  AST_DIS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (status[B_TXEMPTY] && !status[B_RXNEMP]));  // R9
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && en_d) |=> (tx_valid && $stable(tx_word)
                                         && $stable(tx_nbytes)));  // R4
  AST_DIS_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (!tx_valid && !rx_ready));  // R9
  AST_TXN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_nbytes != 3'd0 && tx_nbytes <= 3'd4));  // R3
endmodule

// File: tb/spi_host_regs_bench.sv
module spi_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, cfg_word, tx_word;
  logic        ctrl_en, irq, tx_valid, rx_ready;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic [2:0]  tx_nbytes;
  logic [31:0] rx_word = '0;
  logic [2:0]  rx_nbytes = 3'd4;

  int checks = 0, failures = 0;
  logic [34:0] model [64];
  int head = 0, tail = 0;
  logic exp_ovf = 1'b0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  spi_host_regs u_spi_host_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .cfg_word(cfg_word), .ctrl_en(ctrl_en), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_word(tx_word),
    .tx_nbytes(tx_nbytes), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_word(rx_word), .rx_nbytes(rx_nbytes));

  task automatic check(string req, logic [34:0] act, logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] cnt_of(int k);
    return (k == 0) ? 3'd4 : 3'(k);
  endfunction

  function automatic logic [31:0] pack_rx(logic [31:0] w, int n);
    return w << (8 * (4 - n));
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // transmit write with model update; decision uses the pre-edge occupancy
  task automatic tx_write(int k, logic [31:0] d);
    @(negedge clk);
    reg_addr = 8'h14 + 8'(4 * k); reg_wdata = d; reg_wr = 1'b1;
    if (tail - head < 4) begin
      model[tail % 64] = {d, cnt_of(k)};
      tail++;
    end else exp_ovf = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rx_push(logic [31:0] w, int n);
    @(negedge clk);
    rx_word = w; rx_nbytes = 3'(n); rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // engine-side monitor, sampled away from the edge
  always @(negedge clk) begin
    #2;
    if (rst_n && tx_valid && tx_ready) begin
      if (tail == head) check("R4 unexpected word", {tx_word, tx_nbytes}, '0);
      else begin
        check("R3 word/count", {tx_word, tx_nbytes}, model[head % 64]);
        head++;
      end
    end
  end

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 irq", 35'(irq), 35'd0);
    check("R1 tx_valid", 35'(tx_valid), 35'd0);
    check("R1 rx_ready", 35'(rx_ready), 35'd0);
    rdreg(8'h04, rd); check("R1 status", 35'(rd), 35'h0B);
    rdreg(8'h00, rd); check("R1 cfg", 35'(rd), 35'd0);
    rdreg(8'h10, rd); check("R1 enable", 35'(rd), 35'd0);
    // R2
    wr(8'h00, 32'hA5A5_0003);
    rdreg(8'h00, rd); check("R2 cfg readback", 35'(rd), 35'hA5A5_0003);
    check("R2 cfg_word", 35'(cfg_word), 35'hA5A5_0003);
    wr(8'h08, 32'hFFFF_FFFF);
    rdreg(8'h08, rd); check("R2 sten width", 35'(rd), 35'h1F);
    wr(8'h08, 32'h0);
    wr(8'h10, 32'h1);
    rdreg(8'h10, rd); check("R2 enable", 35'(rd), 35'd1);
    check("R2 ctrl_en", 35'(ctrl_en), 35'd1);
    check("R10 rx_ready on", 35'(rx_ready), 35'd1);

    // random transmit traffic, R3 R4 R5
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      tx_ready = ($urandom % 2) == 0;
      if (($urandom % 3) == 0) tx_write(int'($urandom % 4), $urandom);
    end
    @(negedge clk); tx_ready = 1'b1;
    repeat (8) @(negedge clk);
    check("R4 drained", 35'(tail - head), 35'd0);
    rdreg(8'h04, rd); check("R5 random ovf flag", 35'(rd[4]), 35'(exp_ovf));
    wr(8'h04, 32'h10);
    tx_ready = 1'b0;

    // directed overflow, R5 R7
    tx_write(1, 32'h0000_0011);
    tx_write(2, 32'h0000_2222);
    tx_write(3, 32'h0033_3333);
    tx_write(0, 32'h4444_4444);
    rdreg(8'h04, rd); check("R7 tx full status", 35'(rd), 35'h08);
    tx_write(0, 32'hDEAD_BEEF);
    rdreg(8'h04, rd); check("R5 ovf set", 35'(rd), 35'h18);
    wr(8'h04, 32'h0F);
    rdreg(8'h04, rd); check("R5 live bits unwritable", 35'(rd), 35'h18);
    wr(8'h04, 32'h10);
    rdreg(8'h04, rd); check("R5 ovf cleared", 35'(rd), 35'h08);
    @(negedge clk); tx_ready = 1'b1;
    repeat (6) @(negedge clk);
    tx_ready = 1'b0;
    check("R4 directed drained", 35'(tail - head), 35'd0);

    // receive path, R6 R7 R10
    rx_push(32'h0000_00AB, 1);
    rdreg(8'h04, rd); check("R7 rx not empty", 35'(rd), 35'h0F);
    rdreg(8'h24, rd); check("R6 one byte", 35'(rd), 35'(pack_rx(32'hAB, 1)));
    rdreg(8'h24, rd); check("R6 empty read", 35'(rd), 35'd0);
    rx_push(32'h00CC_BBAA, 3);
    rx_push(32'h1122_3344, 4);
    rx_push(32'h0000_5566, 2);
    rx_push(32'h0000_0077, 1);
    check("R10 rx full", 35'(rx_ready), 35'd0);
    rdreg(8'h04, rd); check("R7 rx full status", 35'(rd), 35'h07);
    rdreg(8'h24, rd); check("R6 three bytes", 35'(rd), 35'hCC_BBAA00);
    rdreg(8'h24, rd); check("R6 four bytes", 35'(rd), 35'h1122_3344);
    rdreg(8'h24, rd); check("R6 two bytes", 35'(rd), 35'h5566_0000);
    rdreg(8'h24, rd); check("R6 last byte", 35'(rd), 35'h7700_0000);
    check("R10 rx ready again", 35'(rx_ready), 35'd1);

    // interrupt masks, R8
    wr(8'h08, 32'h01);
    @(negedge clk); check("R8 sig mask off", 35'(irq), 35'd0);
    wr(8'h0C, 32'h01);
    @(negedge clk); check("R8 both masks", 35'(irq), 35'd1);
    wr(8'h08, 32'h04);
    @(negedge clk); check("R8 bit clear", 35'(irq), 35'd0);
    wr(8'h0C, 32'h04);
    rx_push(32'h1, 1);
    check("R8 rx not empty irq", 35'(irq), 35'd1);
    rdreg(8'h24, rd);
    check("R8 irq falls", 35'(irq), 35'd0);

    // disable flush, R9
    tx_write(0, 32'hAAAA_0001);
    tx_write(1, 32'hAAAA_0002);
    rx_push(32'h5, 1);
    wr(8'h10, 32'h0);
    head = tail;
    @(negedge clk);
    check("R9 tx_valid low", 35'(tx_valid), 35'd0);
    rdreg(8'h04, rd); check("R9 flushed status", 35'(rd), 35'h0B);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      reg_addr = 8'h14; reg_wdata = 32'h9; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
    end
    rdreg(8'h04, rd); check("R9 writes dropped no ovf", 35'(rd), 35'h0B);
    wr(8'h10, 32'h1);
    @(negedge clk);
    check("R9 empty after re-enable", 35'(tx_valid), 35'd0);
    rdreg(8'h24, rd); check("R9 rx flushed", 35'(rd), 35'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule